// File: doc/BRIEF.md
# Byte-Lane Page-Mode SRAM Controller

This block sits between a simple synchronous host port and an external asynchronous 16-bit SRAM of 128K words. It turns single-word writes, single-word reads and in-page burst reads into chip-enable, write-strobe, output-enable and byte-lane signals. It also drives the data-bus enable for the bidirectional data pins and counts the wait states each access needs.

A host request carries a 17-bit word address, a 2-bit byte mask, write data, and for reads a burst length. The upper 13 address bits pick one of 8K pages and the lower 4 bits pick a word in that page. A burst read keeps every strobe asserted and steps only the low four address bits. A burst never leaves its page: it is cut short after the last word of the page. The first word of any access costs a configurable random-access wait, and each further word of a burst costs a shorter in-page wait.

Top module: `sram_page_ctrl`

## Requirements
- R1: After reset `reqReady` is 1, `memCe1N`, `memWeN`, `memOeN`, `memUbN` and `memLbN` are 1, `memCe2` is 0, and `memDqOe` and `rspValid` are 0.
- R2: While a read is in progress the pins read CE1# = 0, CE2 = 1, WE# = 1, OE# = 0 and `memDqOe` = 0, with `memAddr` equal to the word being read.
- R3: A write drives CE1# = 0, CE2 = 1, WE# = 0, OE# = 1 and `memDqOe` = 1 with the write data on `memDqOut` for `RAND_WAIT` cycles. WE# and OE# are never low together.
- R4: Mask bit 1 selects the upper byte and bit 0 the lower byte. During an access UB# = not mask[1] and LB# = not mask[0]. A write with one mask bit set leaves the other byte of the word unchanged.
- R5: A request whose mask is 2'b00 is consumed in one cycle, drives no strobe, returns no word and changes no memory content. Whenever CE1# is low, at least one of UB#/LB# is low.
- R6: `reqLen` is the number of words minus one. A burst returns consecutive words starting at `reqAddr`, with OE# held low throughout and address bits 16..4 unchanged.
- R7: A burst is clipped so that its last word is word 15 of the page. `rspLast` is 1 only on the final returned word.
- R8: The first word of a read appears `RAND_WAIT` cycles after the accepting edge, and each later word of a burst appears `PAGE_WAIT` cycles after the previous one.
- R9: OE# goes low only when `memDqOe` has been 0 in the current and the previous cycle.
- R10: `reqReady` is 1 only when the block is idle. CE1# is high in every idle cycle, so it rises between any two transactions.
- R11: In returned read data the byte of an unselected lane reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host request present |
| reqReady | output | 1 | Controller idle and accepting |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 17 | Word address |
| reqLen | input | 4 | Burst length minus one (reads only) |
| reqMask | input | 2 | Byte mask, bit 1 upper, bit 0 lower |
| reqWdata | input | 16 | Write data |
| rspValid | output | 1 | Returned word valid |
| rspData | output | 16 | Returned word |
| rspLast | output | 1 | Final word of the request |
| memAddr | output | 17 | SRAM word address |
| memCe1N | output | 1 | Active-low chip enable |
| memCe2 | output | 1 | Active-high chip enable |
| memWeN | output | 1 | Active-low write strobe |
| memOeN | output | 1 | Active-low output enable |
| memUbN | output | 1 | Active-low upper byte lane |
| memLbN | output | 1 | Active-low lower byte lane |
| memDqOut | output | 16 | Data driven toward the SRAM |
| memDqOe | output | 1 | Drive enable for the data pins |
| memDqIn | input | 16 | Data read from the SRAM pins |

## Verification
The assertions watch, on every cycle, that the strobes stay mutually consistent: OE# never meets an active bus drive or its trailing cycle, WE# and OE# never overlap, an enabled chip always has a lane selected, the page bits hold while OE# stays low, and a burst never steps past word 15. Data results can only be shown by the bench's scenarios: the merge of partial writes into a byte-lane memory model, masked-lane zeroing, sequential burst contents, page clipping, and the exact wait-state spacing of returned words.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef struct packed {
    logic load;      // latch a new request with a non-empty mask
    logic step;      // advance the in-page word index
    logic capture;   // sample the read pins this cycle
    logic last;      // captured word is the final one
    logic accessRd;  // read access in progress
    logic accessWr;  // write access in progress
  } ctlStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_READ  = 2'd2
  } ctlState_t;

endpackage

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int PAGE_W    = 4,
  parameter int RAND_WAIT = 4,
  parameter int PAGE_WAIT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [PAGE_W-1:0] reqWord,
  input  logic [PAGE_W-1:0] reqLen,
  input  logic              reqMaskAny,
  output logic              reqReady,
  output ctlStrobe_t        strobe
);

  localparam int WAIT_W = (RAND_WAIT > 1) ? $clog2(RAND_WAIT) : 1;
  localparam logic [WAIT_W-1:0] RAND_LOAD = WAIT_W'(RAND_WAIT - 1);
  localparam logic [WAIT_W-1:0] PAGE_LOAD = WAIT_W'(PAGE_WAIT - 1);
  localparam logic [PAGE_W-1:0] WORD_LAST = '1;

  ctlState_t         state;
  logic [WAIT_W-1:0] waitCnt;
  logic [PAGE_W-1:0] remain;
  logic [PAGE_W-1:0] roomLeft;
  logic [PAGE_W-1:0] clipLen;
  logic              accept;
  logic              waitDone;

  assign reqReady = (state == ST_IDLE);
  assign accept   = reqValid && reqReady;
  assign waitDone = (waitCnt == '0);
  assign roomLeft = WORD_LAST - reqWord;
  assign clipLen  = (reqLen > roomLeft) ? roomLeft : reqLen;

  always_comb begin
    strobe          = '0;
    strobe.load     = accept && reqMaskAny;
    strobe.accessRd = (state == ST_READ);
    strobe.accessWr = (state == ST_WRITE);
    strobe.capture  = (state == ST_READ) && waitDone;
    strobe.step     = strobe.capture && (remain != '0);
    strobe.last     = strobe.capture && (remain == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
      remain  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept && reqMaskAny) begin
            state   <= reqWrite ? ST_WRITE : ST_READ;
            waitCnt <= RAND_LOAD;
            remain  <= reqWrite ? '0 : clipLen;
          end
        end
        ST_WRITE: begin
          if (waitDone) state <= ST_IDLE;
          else          waitCnt <= waitCnt - 1'b1;
        end
        ST_READ: begin
          if (waitDone) begin
            if (remain == '0) begin
              state <= ST_IDLE;
            end else begin
              waitCnt <= PAGE_LOAD;
              remain  <= remain - 1'b1;
            end
          end else begin
            waitCnt <= waitCnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_WAIT_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobe.step) && rstN && $past(rstN)) |-> (waitCnt == PAGE_LOAD && state == ST_READ)); // R8

  AST_FINISH_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.last |=> reqReady); // R10

endmodule

// File: rtl/sram_ctl_dp.sv
module sram_ctl_dp
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 16,
  parameter int PAGE_W = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctlStrobe_t                strobe,
  input  logic [ADDR_W-1:0]         reqAddr,
  input  logic [DATA_W/8-1:0]       reqMask,
  input  logic [DATA_W-1:0]         reqWdata,
  output logic                      rspValid,
  output logic [DATA_W-1:0]         rspData,
  output logic                      rspLast,
  output logic [ADDR_W-1:0]         memAddr,
  output logic                      memCe1N,
  output logic                      memCe2,
  output logic                      memWeN,
  output logic                      memOeN,
  output logic [DATA_W/8-1:0]       memLaneN,
  output logic [DATA_W-1:0]         memDqOut,
  output logic                      memDqOe,
  input  logic [DATA_W-1:0]         memDqIn
);

  localparam int LANES = DATA_W / 8;

  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] wdataReg;
  logic [LANES-1:0]  maskReg;
  logic [DATA_W-1:0] laneBits;
  logic              active;

  assign active = strobe.accessRd || strobe.accessWr;

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    assign laneBits[ln*8 +: 8] = {8{maskReg[ln]}};
    assign memLaneN[ln]        = !(active && maskReg[ln]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg  <= '0;
      wdataReg <= '0;
      maskReg  <= '0;
    end else if (strobe.load) begin
      addrReg  <= reqAddr;
      wdataReg <= reqWdata;
      maskReg  <= reqMask;
    end else if (strobe.step) begin
      addrReg[PAGE_W-1:0] <= addrReg[PAGE_W-1:0] + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspLast  <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= strobe.capture;
      rspLast  <= strobe.last;
      if (strobe.capture) rspData <= memDqIn & laneBits;
    end
  end

  assign memAddr  = addrReg;
  assign memCe1N  = !active;
  assign memCe2   = active;
  assign memWeN   = !strobe.accessWr;
  assign memOeN   = !strobe.accessRd;
  assign memDqOe  = strobe.accessWr;
  assign memDqOut = wdataReg;

  AST_BUS_TURN: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> (!memDqOe && !$past(memDqOe))); // R9

  AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(!memWeN && !memOeN)); // R3

  AST_LANE_SELECTED: assert property (@(posedge clk) disable iff (!rstN)
    !memCe1N |-> (memLaneN != '1)); // R5

  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!memOeN && $past(!memOeN) && $past(rstN)) |->
      (memAddr[ADDR_W-1:PAGE_W] == $past(memAddr[ADDR_W-1:PAGE_W]))); // R6

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |-> (memAddr[PAGE_W-1:0] != '1)); // R7

endmodule

// File: rtl/sram_page_ctrl.sv
module sram_page_ctrl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int DATA_W    = 16,
  parameter int PAGE_W    = 4,
  parameter int RAND_WAIT = 4,
  parameter int PAGE_WAIT = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [PAGE_W-1:0]   reqLen,
  input  logic [DATA_W/8-1:0] reqMask,
  input  logic [DATA_W-1:0]   reqWdata,
  output logic                rspValid,
  output logic [DATA_W-1:0]   rspData,
  output logic                rspLast,
  output logic [ADDR_W-1:0]   memAddr,
  output logic                memCe1N,
  output logic                memCe2,
  output logic                memWeN,
  output logic                memOeN,
  output logic                memUbN,
  output logic                memLbN,
  output logic [DATA_W-1:0]   memDqOut,
  output logic                memDqOe,
  input  logic [DATA_W-1:0]   memDqIn
);

  ctlStrobe_t       strobe;
  logic [DATA_W/8-1:0] laneN;

  sram_ctl_fsm #(
    .PAGE_W(PAGE_W), .RAND_WAIT(RAND_WAIT), .PAGE_WAIT(PAGE_WAIT)
  ) u_fsm (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqWord(reqAddr[PAGE_W-1:0]), .reqLen(reqLen), .reqMaskAny(|reqMask),
    .reqReady(reqReady), .strobe(strobe)
  );

  sram_ctl_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr),
    .reqMask(reqMask), .reqWdata(reqWdata), .rspValid(rspValid),
    .rspData(rspData), .rspLast(rspLast), .memAddr(memAddr),
    .memCe1N(memCe1N), .memCe2(memCe2), .memWeN(memWeN), .memOeN(memOeN),
    .memLaneN(laneN), .memDqOut(memDqOut), .memDqOe(memDqOe),
    .memDqIn(memDqIn)
  );

  assign memLbN = laneN[0];
  assign memUbN = laneN[DATA_W/8-1];

endmodule

// File: tb/sram_page_ctrl_tb.sv
module sram_page_ctrl_tb;

  localparam int RW = 4;
  localparam int PW = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [16:0] reqAddr = '0;
  logic [3:0]  reqLen = '0;
  logic [1:0]  reqMask = '0;
  logic [15:0] reqWdata = '0;
  logic        reqReady, rspValid, rspLast;
  logic [15:0] rspData, memDqOut;
  logic [16:0] memAddr;
  logic        memCe1N, memCe2, memWeN, memOeN, memUbN, memLbN, memDqOe;
  logic [15:0] memDqIn = '0;

  always #2 clk = ~clk;

  sram_page_ctrl #(.RAND_WAIT(RW), .PAGE_WAIT(PW)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqLen(reqLen),
    .reqMask(reqMask), .reqWdata(reqWdata), .rspValid(rspValid),
    .rspData(rspData), .rspLast(rspLast), .memAddr(memAddr),
    .memCe1N(memCe1N), .memCe2(memCe2), .memWeN(memWeN), .memOeN(memOeN),
    .memUbN(memUbN), .memLbN(memLbN), .memDqOut(memDqOut),
    .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  int checks = 0, errors = 0;
  int cyc = 0, refCyc = 0, turnViol = 0;
  bit finished = 0, prevDqOe = 0;

  typedef struct { logic [15:0] data; logic last; int gap; } expItem_t;
  expItem_t expQ[$];

  logic [15:0] sramMem [int];
  logic [15:0] shadow  [int];

  function automatic logic [15:0] initVal(int a);
    return 16'((a * 16'h9E37) ^ 16'h3C5A);
  endfunction

  function automatic logic [15:0] memGet(int a);
    return sramMem.exists(a) ? sramMem[a] : initVal(a);
  endfunction

  function automatic logic [15:0] shGet(int a);
    return shadow.exists(a) ? shadow[a] : initVal(a);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // behavioural byte-lane SRAM
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!memCe1N && memCe2 && !memWeN) begin
      logic [15:0] w;
      w = memGet(int'(memAddr));
      if (!memLbN) w[7:0]  = memDqOut[7:0];
      if (!memUbN) w[15:8] = memDqOut[15:8];
      sramMem[int'(memAddr)] = w;
    end
  end

  always @(negedge clk) begin
    memDqIn <= (!memCe1N && memCe2 && !memOeN) ? memGet(int'(memAddr)) : 16'hDEAD;
  end

  // monitor: scoreboard and bus turnaround watch
  always @(negedge clk) begin
    if (rstN) begin
      if (!memOeN && (memDqOe || prevDqOe)) turnViol++;
      prevDqOe = memDqOe;
      if (rspValid) begin
        if (expQ.size() == 0) begin
          chk(0, "R5", "unexpected word", int'(rspData), 0);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          chk(rspData == e.data, "R6/R11 (R4)", "read data", int'(rspData), int'(e.data));
          chk(rspLast == e.last, "R7", "last flag", int'(rspLast), int'(e.last));
          chk(cyc - refCyc == e.gap, "R8", "word spacing", cyc - refCyc, e.gap);
          refCyc = cyc;
        end
      end
    end
  end

  task automatic issue(bit wr, int addr, int len, logic [1:0] mask, logic [15:0] wd);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqWrite = wr; reqAddr = 17'(addr); reqLen = 4'(len);
    reqMask = mask; reqWdata = wd; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    refCyc = cyc;
  endtask

  task automatic waitIdle();
    while (!reqReady || expQ.size() != 0) @(negedge clk);
    @(negedge clk);
    chk(memCe1N == 1'b1, "R10", "CE1# high when idle", int'(memCe1N), 1);
  endtask

  task automatic doWrite(int addr, logic [1:0] mask, logic [15:0] wd);
    logic [15:0] w;
    issue(1, addr, 0, mask, wd);
    if (mask != 2'b00) begin
      chk({memCe1N, memCe2, memWeN, memOeN, memDqOe} == 5'b01011, "R3",
          "write strobes", int'({memCe1N, memCe2, memWeN, memOeN, memDqOe}), 'b01011);
      chk(memDqOut == wd, "R3", "write data", int'(memDqOut), int'(wd));
      chk({memUbN, memLbN} == ~mask, "R4", "write lanes", int'({memUbN, memLbN}), int'(~mask));
      chk(reqReady == 1'b0, "R10", "busy during write", int'(reqReady), 0);
      w = shGet(addr);
      if (mask[0]) w[7:0]  = wd[7:0];
      if (mask[1]) w[15:8] = wd[15:8];
      shadow[addr] = w;
    end
    waitIdle();
  endtask

  task automatic doRead(int addr, int len, logic [1:0] mask);
    int room, n;
    logic [15:0] lm;
    room = 15 - (addr % 16);
    n = ((len > room) ? room : len) + 1;
    lm = {{8{mask[1]}}, {8{mask[0]}}};
    for (int i = 0; i < n; i++) begin
      expItem_t e;
      e.data = shGet(addr + i) & lm;
      e.last = (i == n - 1);
      e.gap  = (i == 0) ? RW : PW;
      expQ.push_back(e);
    end
    issue(0, addr, len, mask, 16'h0);
    chk({memCe1N, memCe2, memWeN, memOeN, memDqOe} == 5'b01100, "R2",
        "read strobes", int'({memCe1N, memCe2, memWeN, memOeN, memDqOe}), 'b01100);
    chk(memAddr == 17'(addr), "R2", "read address", int'(memAddr), addr);
    chk({memUbN, memLbN} == ~mask, "R4", "read lanes", int'({memUbN, memLbN}), int'(~mask));
    waitIdle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady == 1'b1, "R1", "ready after reset", int'(reqReady), 1);
    chk({memCe1N, memCe2, memWeN, memOeN, memUbN, memLbN} == 6'b101111, "R1",
        "idle pins", int'({memCe1N, memCe2, memWeN, memOeN, memUbN, memLbN}), 'b101111);
    chk({memDqOe, rspValid} == 2'b00, "R1", "bus and response idle",
        int'({memDqOe, rspValid}), 0);

    doWrite(16'h1000, 2'b11, 16'h1234);
    doWrite(16'h1000, 2'b10, 16'hABFF);   // R4 upper only
    doWrite(16'h1001, 2'b01, 16'hFF77);   // R4 lower only
    doRead(16'h1000, 1, 2'b11);

    // R5: empty mask write and read
    issue(1, 16'h1000, 0, 2'b00, 16'h5555);
    for (int i = 0; i < RW + 2; i++) begin
      chk(memCe1N && memWeN && reqReady, "R5", "no access for empty mask",
          int'({memCe1N, memWeN, reqReady}), 'b111);
      @(negedge clk);
    end
    issue(0, 16'h1000, 3, 2'b00, 16'h0);
    repeat (RW + 3) @(negedge clk);
    chk(memCe1N == 1'b1, "R5", "no read for empty mask", int'(memCe1N), 1);
    doRead(16'h1000, 0, 2'b11);           // content unchanged

    doRead(17'h12340, 15, 2'b11);         // R6 full page
    doRead(17'h0F00E, 7, 2'b11);          // R7 clipped to two words
    doRead(17'h0F00F, 3, 2'b10);          // R7 single word at page end
    doRead(16'h1000, 2, 2'b01);           // R11 upper lane zero
    doRead(16'h1001, 0, 2'b10);           // R11 lower lane zero

    chk(turnViol == 0, "R9", "OE# low next to bus drive", turnViol, 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule